// File: doc/BRIEF.md
# Accumulator Load Addressing Sequencer

This block carries out the load step of a small accumulator machine. A one-cycle start strobe comes with a 2-bit addressing mode and an operand field. The mode sets how the operand is used.

- **Immediate:** the operand itself goes into the accumulator.
- **Direct:** the operand is a memory address, and the word read there is loaded.
- **Indirect:** the operand points to a memory word that holds the address of the value to load.

The block owns one read port of an external synchronous single-port RAM. The RAM returns data one cycle after the read enable is sampled. A small state machine issues zero, one or two dependent reads to match the mode. It then writes the accumulator and signals completion with a one-cycle done pulse. An illegal mode code finishes at once with an error pulse and leaves the accumulator as it was.

While a load is in flight the block reports busy and ignores new start strobes. A surrounding sequencer simply waits for done, or for busy to fall, before it issues the next load.

Top module: `acc_load_seq`

## Requirements
- R1: Mode code 00 (immediate) writes the operand into the accumulator with no memory read; done is high in the cycle after the start edge.
- R2: Mode code 01 (direct) issues exactly one read at the operand address in the start cycle; the accumulator takes the returned word and done is high two cycles after the start edge.
- R3: Mode code 10 (indirect) reads first at the operand address, then at the address equal to the word returned by that first read; the accumulator takes the second word and done is high three cycles after the start edge.
- R4: Mode code 11 is illegal: no memory read, the accumulator keeps its value, and err_o and done_o are both high for one cycle, one cycle after the start edge.
- R5: busy_o is high from the cycle after an accepted start up to and including the done cycle, and low when idle.
- R6: A start strobe while busy_o is high is ignored: it issues no read, writes nothing to the accumulator, and leaves the running load's result and timing unchanged.
- R7: done_o is a single-cycle pulse, and the accumulator holds its value outside load completion.
- R8: After reset the accumulator is zero and busy_o, done_o and err_o are low.
- R9: A start in the first cycle with busy_o low, right after a done pulse, is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for one load |
| mode_i | input | 2 | Addressing mode: 00 immediate, 01 direct, 10 indirect, 11 illegal |
| operand_i | input | W | Operand field (value or address) |
| mem_re_o | output | 1 | RAM read enable |
| mem_addr_o | output | W | RAM read address |
| mem_rdata_i | input | W | RAM read data, valid one cycle after read enable |
| acc_o | output | W | Accumulator value |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load complete pulse |
| err_o | output | 1 | Illegal mode pulse, coincides with done |

## Verification
The functions that can meet in one cycle are the done pulse of one load and the start strobe of the next. The bench asserts a new start exactly in the cycle where done is seen. It then judges that strobe as ignored, because no read follows and the accumulator and done do not change. It repeats the test with a start one cycle later and judges that one as accepted. It also drives start during the dependent-read cycle of an indirect load. There the pointer return and the second address issue overlap, and the bench confirms that the second read address still equals the pointer word.

// File: rtl/acc_load_pkg.sv
package acc_load_pkg;

    typedef enum logic [1:0] {
        MODE_IMM = 2'b00,
        MODE_DIR = 2'b01,
        MODE_IND = 2'b10,
        MODE_BAD = 2'b11
    } load_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_PTR  = 2'b01,
        ST_DATA = 2'b10
    } seq_state_e;

endpackage

// File: rtl/ald_accum.sv
module ald_accum #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] acc_o
);
    logic [W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (we_i) acc_d = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc_o = acc_q;

    // R7: without a write strobe the accumulator holds
    a_r7_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> acc_q == $past(acc_q));

endmodule

// File: rtl/ald_ctrl.sv
module ald_ctrl
    import acc_load_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] operand_i,
    input  logic [W-1:0] mem_rdata_i,
    output logic         mem_re_o,
    output logic [W-1:0] mem_addr_o,
    output logic         acc_we_o,
    output logic [W-1:0] acc_wdata_o,
    output logic         busy_o,
    output logic         done_o,
    output logic         err_o
);
    typedef struct packed {
        seq_state_e state;
        logic       done;
        logic       err;
    } ctrl_s;

    ctrl_s      r_d, r_q;
    load_mode_e mode;
    logic       accept;

    assign mode   = load_mode_e'(mode_i);
    assign accept = start_i && (r_q.state == ST_IDLE) && !r_q.done;

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.err     = 1'b0;
        mem_re_o    = 1'b0;
        mem_addr_o  = operand_i;
        acc_we_o    = 1'b0;
        acc_wdata_o = operand_i;
        unique case (r_q.state)
            ST_IDLE: begin
                if (accept) begin
                    unique case (mode)
                        MODE_IMM: begin
                            acc_we_o = 1'b1;
                            r_d.done = 1'b1;
                        end
                        MODE_DIR: begin
                            mem_re_o  = 1'b1;
                            r_d.state = ST_DATA;
                        end
                        MODE_IND: begin
                            mem_re_o  = 1'b1;
                            r_d.state = ST_PTR;
                        end
                        default: begin
                            r_d.done = 1'b1;
                            r_d.err  = 1'b1;
                        end
                    endcase
                end
            end
            ST_PTR: begin
                mem_re_o   = 1'b1;
                mem_addr_o = mem_rdata_i;
                r_d.state  = ST_DATA;
            end
            ST_DATA: begin
                acc_we_o    = 1'b1;
                acc_wdata_o = mem_rdata_i;
                r_d.done    = 1'b1;
                r_d.state   = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, done: 1'b0, err: 1'b0};
        else        r_q <= r_d;
    end

    assign busy_o = (r_q.state != ST_IDLE) || r_q.done;
    assign done_o = r_q.done;
    assign err_o  = r_q.err;

    // R6: a strobe in the done cycle starts nothing
    a_r6_start_in_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && r_q.done) |-> (!mem_re_o && !acc_we_o));
    // R7: done lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);
    // R4: error only together with done
    a_r4_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err |-> r_q.done);
    // R3: second indirect read follows the pointer read
    a_r3_ptr_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PTR) |-> ($past(mem_re_o) && mem_re_o));

endmodule

// File: rtl/acc_load_seq.sv
module acc_load_seq
    import acc_load_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] operand_i,
    output logic         mem_re_o,
    output logic [W-1:0] mem_addr_o,
    input  logic [W-1:0] mem_rdata_i,
    output logic [W-1:0] acc_o,
    output logic         busy_o,
    output logic         done_o,
    output logic         err_o
);
    logic         acc_we;
    logic [W-1:0] acc_wdata;

    ald_ctrl #(.W(W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .operand_i   (operand_i),
        .mem_rdata_i (mem_rdata_i),
        .mem_re_o    (mem_re_o),
        .mem_addr_o  (mem_addr_o),
        .acc_we_o    (acc_we),
        .acc_wdata_o (acc_wdata),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );

    ald_accum #(.W(W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (acc_we),
        .wdata_i (acc_wdata),
        .acc_o   (acc_o)
    );

    logic go;
    assign go = start_i && !busy_o;

    // R1: immediate loads the operand after one cycle, no read
    a_r1_imm: assert property (@(posedge clk) disable iff (!rst_n)
        (go && mode_i == MODE_IMM) |-> (!mem_re_o ##1 (done_o && acc_o == $past(operand_i))));
    // R2: direct reads at the operand and finishes in two cycles
    a_r2_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (go && mode_i == MODE_DIR) |-> ((mem_re_o && mem_addr_o == operand_i) ##1 !done_o ##1 done_o));
    // R3: indirect finishes in three cycles
    a_r3_ind: assert property (@(posedge clk) disable iff (!rst_n)
        (go && mode_i == MODE_IND) |-> ((mem_re_o && mem_addr_o == operand_i) ##1 !done_o ##1 !done_o ##1 done_o));
    // R4: illegal mode leaves accumulator alone and flags error
    a_r4_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (go && mode_i == MODE_BAD) |-> (!mem_re_o ##1 (done_o && err_o && $stable(acc_o))));
    // R5: busy covers the done cycle
    a_r5_busy_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

endmodule

// File: tb/tb_acc_load_seq.sv
module tb_acc_load_seq;
    localparam int W     = 8;
    localparam int DEPTH = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] operand = '0;
    logic         mem_re;
    logic [W-1:0] mem_addr;
    logic [W-1:0] mem_rdata = '0;
    logic [W-1:0] acc;
    logic         busy, done, err;

    logic [W-1:0] ram [DEPTH];
    int           rd_cnt = 0;
    logic [W-1:0] rd_addr [4];
    int           n_run = 0;
    int           n_fail = 0;

    always #10 clk = ~clk;

    acc_load_seq #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .operand_i(operand), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
        .mem_rdata_i(mem_rdata), .acc_o(acc), .busy_o(busy),
        .done_o(done), .err_o(err)
    );

    always @(posedge clk) begin
        if (mem_re) begin
            mem_rdata <= ram[mem_addr];
            if (rd_cnt < 4) rd_addr[rd_cnt] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called just after a negedge; drives a start and follows the load.
    task automatic run_load(input string req, input logic [1:0] m, input logic [W-1:0] op,
                            input int exp_acc, input int exp_cyc, input int exp_err,
                            input int exp_reads);
        int cyc = 0;
        rd_cnt = 0;
        start = 1'b1; mode = m; operand = op;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 8) begin
            chk({req, " busy during load (R5)"}, busy, 1);
            @(negedge clk);
            cyc++;
        end
        chk({req, " latency"}, cyc, exp_cyc);
        chk({req, " accumulator"}, acc, exp_acc);
        chk({req, " error flag"}, err, exp_err);
        chk({req, " busy in done cycle (R5)"}, busy, 1);
        chk({req, " read count"}, rd_cnt, exp_reads);
        @(negedge clk);
        chk({req, " done single pulse (R7)"}, done, 0);
        chk({req, " idle busy low (R5)"}, busy, 0);
        chk({req, " accumulator held (R7)"}, acc, exp_acc);
    endtask

    task automatic t_reset;
        chk("R8 acc after reset", acc, 0);
        chk("R8 busy after reset", busy, 0);
        chk("R8 done after reset", done, 0);
        chk("R8 err after reset", err, 0);
    endtask

    task automatic t_imm;
        run_load("R1 imm 0x3c", 2'b00, 8'h3c, 8'h3c, 1, 0, 0);
        run_load("R1 imm 0xff", 2'b00, 8'hff, 8'hff, 1, 0, 0);
    endtask

    task automatic t_dir;
        run_load("R2 dir 0x20", 2'b01, 8'h20, int'(ram[8'h20]), 2, 0, 1);
        chk("R2 read address", rd_addr[0], 8'h20);
        run_load("R2 dir 0x00", 2'b01, 8'h00, int'(ram[8'h00]), 2, 0, 1);
    endtask

    task automatic t_ind;
        run_load("R3 ind 5", 2'b10, 8'd5, 8'hA7, 3, 0, 2);
        chk("R3 first address", rd_addr[0], 5);
        chk("R3 second address", rd_addr[1], 10);
        run_load("R3 ind self pointer", 2'b10, 8'd200, 8'd200, 3, 0, 2);
    endtask

    task automatic t_bad;
        run_load("R4 imm preload", 2'b00, 8'h5a, 8'h5a, 1, 0, 0);
        run_load("R4 illegal mode", 2'b11, 8'h11, 8'h5a, 1, 1, 0);
    endtask

    task automatic t_ignore;
        int cyc = 0;
        // strobe during the pointer-return cycle of an indirect load
        rd_cnt = 0;
        start = 1'b1; mode = 2'b10; operand = 8'd5;
        @(negedge clk);
        mode = 2'b00; operand = 8'h33;
        cyc = 1;
        while (!done && cyc < 8) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        chk("R6 latency unchanged", cyc, 3);
        chk("R6 result unchanged", acc, 8'hA7);
        chk("R6 second address kept", rd_addr[1], 10);
        // strobe in the done cycle
        start = 1'b1; mode = 2'b00; operand = 8'h44;
        @(negedge clk);
        start = 1'b0;
        chk("R6 done-cycle start no done", done, 0);
        chk("R6 done-cycle start acc", acc, 8'hA7);
        chk("R6 reads total", rd_cnt, 2);
        chk("R6 busy low after", busy, 0);
    endtask

    task automatic t_b2b;
        // R9: run_load returns at the first idle cycle; next start goes there
        run_load("R9 first", 2'b01, 8'd10, 8'hA7, 2, 0, 1);
        run_load("R9 back to back", 2'b00, 8'h81, 8'h81, 1, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) ram[i] = W'((i * 37 + 11) % DEPTH);
        ram[5]   = 8'd10;
        ram[10]  = 8'hA7;
        ram[200] = 8'd200;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_imm();
        t_dir();
        t_ind();
        t_bad();
        t_ignore();
        t_b2b();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule